// File: doc/BRIEF.md
# Region-Aware Fetch Address Generator

This unit holds the program counter of a small processor core and turns it into a fetch address. The core runs code from three stores: a 512-word register memory, a 512-word lookup memory, and a large shared memory addressed in bytes. Counter values below $400 are word addresses. Values $000 to $1FF select the register memory and $200 to $3FF select the lookup memory. Values at or above $400 are byte addresses into shared memory.

Each cycle that the core advances, the unit either steps to the next instruction or takes a branch. A branch is either absolute or relative, with a signed 9-bit instruction offset. The outputs give the region to fetch from, the local address inside that region, the raw counter, and a flag that shows shared-memory execution. That flag is set only by a taken branch. If code runs off the end of the lookup memory without branching, the counter keeps counting upward while the fetches wrap back to the register memory.

Top module: `region_pc`

## Requirements
- R1: While `rst` is high at a clock edge, the counter becomes $00000, the shared flag clears, the region becomes 2'b00 and the local address becomes 0. Reset takes priority over `step_en`.
- R2: When `step_en` is high, `br_take` is low and the shared flag is clear, the counter increases by 1.
- R3: When `step_en` is high, `br_take` is low and the shared flag is set, the counter increases by 4.
- R4: When `step_en`, `br_take` and `br_rel` are all high, the new counter is the address of the next instruction plus the 9-bit two's-complement offset `br_ofs` (range -256 to +255). The next instruction is at counter+1 with the flag clear, or counter+4 with it set. The offset is multiplied by 4 when the flag is set. The sum wraps modulo 2^20, and a sum at or above $400 is used as a byte address as it stands.
- R5: When `step_en` and `br_take` are high and `br_rel` is low, the new counter equals `br_abs_tgt`.
- R6: After a taken branch, the shared flag is 1 if the new counter is at or above $400, and 0 if it is below $400.
- R7: A sequential step never changes the shared flag. When the flag is clear and the counter is at or above $400, the region and local address are decoded from the counter modulo $400, so fetch at $400 goes to register word 0.
- R8: Region encoding: 2'b00 is register memory (word-mode value $000 to $1FF), 2'b01 is lookup memory ($200 to $3FF), and 2'b10 is shared memory (flag set). In word mode the local address is the low 9 bits of the counter, zero-extended. In shared mode it is the full counter.
- R9: When `step_en` is low, the counter and the flag hold their values, and the branch inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the counter this cycle |
| br_take | input | 1 | Taken branch on this advance |
| br_rel | input | 1 | 1: relative branch, 0: absolute branch |
| br_abs_tgt | input | 20 | Absolute branch target |
| br_ofs | input | 9 | Signed relative offset, in instructions |
| pc_value | output | 20 | Current counter |
| shmem_mode | output | 1 | Shared-memory execution flag |
| fetch_region | output | 2 | Region to fetch from |
| fetch_local | output | 20 | Address inside the region |

## Verification
A wrong counter or a wrong flag shows up at the ports on the first sampled cycle after the clock edge that produced it. The reason is that the region and the local address are decoded directly from those two registers. A bad step size appears as a wrong `pc_value` after a single advance. A flag that is set or cleared at the wrong time shows up as a wrong `fetch_region` at once, and also as a wrong step size on the next advance. The vector walk sweeps through several cases: a crossing from register to lookup memory, running off $3FF, entering and leaving shared memory through relative branches, and wrap-around of the counter at 2^20.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    localparam int PC_W        = 20;
    localparam int OFS_W       = 9;
    localparam int RAM_WORDS   = 512;
    localparam int INSTR_BYTES = 4;
    localparam int LOCAL_W     = $clog2(RAM_WORDS);
    localparam int INSTR_SHIFT = $clog2(INSTR_BYTES);
    localparam logic [PC_W-1:0] WORD_SPACE = PC_W'(2 * RAM_WORDS);

    typedef enum logic [1:0] {
        RGN_REG    = 2'b00,
        RGN_LUT    = 2'b01,
        RGN_SHARED = 2'b10
    } region_e;

    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            shared;
    } pc_state_t;

    typedef struct packed {
        logic             take;
        logic             rel;
        logic [PC_W-1:0]  abs_tgt;
        logic [OFS_W-1:0] ofs;
    } branch_req_t;

    typedef struct packed {
        region_e         region;
        logic [PC_W-1:0] local_addr;
    } fetch_info_t;

    function automatic logic [PC_W-1:0] sext_ofs(input logic [OFS_W-1:0] o);
        return {{(PC_W-OFS_W){o[OFS_W-1]}}, o};
    endfunction

    function automatic logic in_shared_space(input logic [PC_W-1:0] a);
        return a >= WORD_SPACE;
    endfunction

endpackage

// File: rtl/pcu_step_gen.sv
module pcu_step_gen
    import pcu_pkg::*;
#(
    parameter int W     = PC_W,
    parameter int SHIFT = INSTR_SHIFT
) (
    input  logic [W-1:0] pc,
    input  logic         shared,
    output logic [W-1:0] seq_next
);
    localparam logic [W-1:0] WORD_INC  = W'(1);
    localparam logic [W-1:0] SHARE_INC = W'(1) << SHIFT;

    always_comb begin
        seq_next = pc + (shared ? SHARE_INC : WORD_INC);
    end
endmodule

// File: rtl/pcu_branch_tgt.sv
module pcu_branch_tgt
    import pcu_pkg::*;
#(
    parameter int W     = PC_W,
    parameter int SHIFT = INSTR_SHIFT
) (
    input  logic [W-1:0] seq_next,
    input  logic         shared,
    input  branch_req_t  req,
    output logic [W-1:0] target
);
    logic [W-1:0] ofs_ext;
    logic [W-1:0] ofs_scaled;

    always_comb begin
        ofs_ext    = sext_ofs(req.ofs);
        ofs_scaled = shared ? (ofs_ext << SHIFT) : ofs_ext;
        if (req.rel) target = seq_next + ofs_scaled;
        else         target = req.abs_tgt;
    end
endmodule

// File: rtl/pcu_region_dec.sv
module pcu_region_dec
    import pcu_pkg::*;
#(
    parameter int W  = PC_W,
    parameter int LW = LOCAL_W
) (
    input  pc_state_t   st,
    output fetch_info_t info
);
    logic [W-1:0] wrapped;

    always_comb begin
        wrapped = st.pc & (WORD_SPACE - W'(1));
        if (st.shared) begin
            info.region     = RGN_SHARED;
            info.local_addr = st.pc;
        end else begin
            info.region     = wrapped[LW] ? RGN_LUT : RGN_REG;
            info.local_addr = {{(W-LW){1'b0}}, wrapped[LW-1:0]};
        end
    end
endmodule

// File: rtl/region_pc.sv
module region_pc
    import pcu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               step_en,
    input  logic               br_take,
    input  logic               br_rel,
    input  logic [PC_W-1:0]    br_abs_tgt,
    input  logic [OFS_W-1:0]   br_ofs,
    output logic [PC_W-1:0]    pc_value,
    output logic               shmem_mode,
    output logic [1:0]         fetch_region,
    output logic [PC_W-1:0]    fetch_local
);
    pc_state_t   st_q;
    pc_state_t   st_d;
    branch_req_t req;
    fetch_info_t info;
    logic [PC_W-1:0] seq_next;
    logic [PC_W-1:0] target;

    assign req = '{take: br_take, rel: br_rel, abs_tgt: br_abs_tgt, ofs: br_ofs};

    pcu_step_gen #(.W(PC_W), .SHIFT(INSTR_SHIFT)) u_step (
        .pc       (st_q.pc),
        .shared   (st_q.shared),
        .seq_next (seq_next)
    );

    pcu_branch_tgt #(.W(PC_W), .SHIFT(INSTR_SHIFT)) u_tgt (
        .seq_next (seq_next),
        .shared   (st_q.shared),
        .req      (req),
        .target   (target)
    );

    always_comb begin
        st_d = st_q;
        if (step_en) begin
            if (req.take) begin
                st_d.pc     = target;
                st_d.shared = in_shared_space(target);
            end else begin
                st_d.pc     = seq_next;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: '0, shared: 1'b0};
        else     st_q <= st_d;
    end

    pcu_region_dec #(.W(PC_W), .LW(LOCAL_W)) u_dec (
        .st   (st_q),
        .info (info)
    );

    assign pc_value     = st_q.pc;
    assign shmem_mode   = st_q.shared;
    assign fetch_region = info.region;
    assign fetch_local  = info.local_addr;
endmodule

// File: rtl/region_pc_chk.sv
module region_pc_chk
    import pcu_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             br_take,
    input logic             br_rel,
    input logic [PC_W-1:0]  br_abs_tgt,
    input logic [PC_W-1:0]  pc_value,
    input logic             shmem_mode,
    input logic [1:0]       fetch_region
);
    logic seen_edge;
    always_ff @(posedge clk) seen_edge <= 1'b1;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (pc_value == '0 && !shmem_mode));

    p_seq_word_r2: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (step_en && !br_take && !shmem_mode) |=> pc_value == $past(pc_value) + PC_W'(1));

    p_seq_shared_r3: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (step_en && !br_take && shmem_mode) |=> pc_value == $past(pc_value) + PC_W'(INSTR_BYTES));

    p_abs_load_r5: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (step_en && br_take && !br_rel) |=> pc_value == $past(br_abs_tgt));

    p_mode_on_branch_r6: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (step_en && br_take) |=> shmem_mode == (pc_value >= WORD_SPACE));

    p_seq_keeps_mode_r7: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        (step_en && !br_take) |=> $stable(shmem_mode));

    p_hold_r9: assert property (@(posedge clk) disable iff (rst || !seen_edge)
        !step_en |=> ($stable(pc_value) && $stable(shmem_mode)));

    always_comb begin
        if (seen_edge) begin
            p_region_enc_r8: assert (shmem_mode == (fetch_region == RGN_SHARED))
                else $error("region code disagrees with shared flag");
        end
    end
endmodule

bind region_pc region_pc_chk u_chk (.*);

// File: tb/sim_region_pc.sv
module sim_region_pc;
    import pcu_pkg::*;

    typedef struct packed {
        logic             step;
        logic             take;
        logic             rel;
        logic [PC_W-1:0]  abs_tgt;
        logic [OFS_W-1:0] ofs;
        logic [PC_W-1:0]  exp_pc;
        logic             exp_mode;
        logic [1:0]       exp_rgn;
        logic [PC_W-1:0]  exp_loc;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00001,1'b0,2'b00,20'h00001,4'd2}, // R2
        '{1'b1,1'b1,1'b0,20'h001F0,9'h000,20'h001F0,1'b0,2'b00,20'h001F0,4'd5}, // R5
        '{1'b1,1'b1,1'b1,20'h00000,9'h020,20'h00211,1'b0,2'b01,20'h00011,4'd4}, // R4 reg->lut
        '{1'b1,1'b1,1'b1,20'h00000,9'h1FD,20'h0020F,1'b0,2'b01,20'h0000F,4'd4}, // R4 negative
        '{1'b0,1'b1,1'b0,20'h12345,9'h0AA,20'h0020F,1'b0,2'b01,20'h0000F,4'd9}, // R9 hold
        '{1'b1,1'b1,1'b0,20'h003FE,9'h000,20'h003FE,1'b0,2'b01,20'h001FE,4'd5}, // R5
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h003FF,1'b0,2'b01,20'h001FF,4'd2}, // R2
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00400,1'b0,2'b00,20'h00000,4'd7}, // R7 wrap
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00401,1'b0,2'b00,20'h00001,4'd7}, // R7
        '{1'b1,1'b1,1'b0,20'h00380,9'h000,20'h00380,1'b0,2'b01,20'h00180,4'd8}, // R8
        '{1'b1,1'b1,1'b1,20'h00000,9'h0FF,20'h00480,1'b1,2'b10,20'h00480,4'd6}, // R6 enter
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00484,1'b1,2'b10,20'h00484,4'd3}, // R3
        '{1'b1,1'b1,1'b1,20'h00000,9'h1FE,20'h00480,1'b1,2'b10,20'h00480,4'd4}, // R4 scaled
        '{1'b1,1'b1,1'b1,20'h00000,9'h100,20'h00084,1'b0,2'b00,20'h00084,4'd6}, // R6 leave
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00085,1'b0,2'b00,20'h00085,4'd2}, // R2
        '{1'b1,1'b1,1'b0,20'hFFFFC,9'h000,20'hFFFFC,1'b1,2'b10,20'hFFFFC,4'd6}, // R6
        '{1'b1,1'b0,1'b0,20'h00000,9'h000,20'h00000,1'b1,2'b10,20'h00000,4'd3}, // R3 wrap 2^20
        '{1'b1,1'b1,1'b1,20'h00000,9'h000,20'h00004,1'b0,2'b00,20'h00004,4'd6}, // R6 clears
        '{1'b1,1'b1,1'b0,20'h007FF,9'h000,20'h007FF,1'b1,2'b10,20'h007FF,4'd5}, // R5
        '{1'b1,1'b1,1'b1,20'h00000,9'h100,20'h00403,1'b1,2'b10,20'h00403,4'd4}, // R4 -256
        '{1'b0,1'b0,1'b1,20'h00000,9'h07F,20'h00403,1'b1,2'b10,20'h00403,4'd9}  // R9
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             step_en;
    logic             br_take;
    logic             br_rel;
    logic [PC_W-1:0]  br_abs_tgt;
    logic [OFS_W-1:0] br_ofs;
    logic [PC_W-1:0]  pc_value;
    logic             shmem_mode;
    logic [1:0]       fetch_region;
    logic [PC_W-1:0]  fetch_local;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    region_pc u0 (
        .clk, .rst, .step_en, .br_take, .br_rel, .br_abs_tgt, .br_ofs,
        .pc_value, .shmem_mode, .fetch_region, .fetch_local
    );

    function automatic string tag(input int r);
        case (r)
            1: return "R1"; 2: return "R2"; 3: return "R3";
            4: return "R4"; 5: return "R5"; 6: return "R6";
            7: return "R7"; 8: return "R8"; 9: return "R9";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input string rq, input logic [PC_W-1:0] epc, input logic em,
                         input logic [1:0] er, input logic [PC_W-1:0] el);
        n_checks++;
        if (pc_value !== epc || shmem_mode !== em || fetch_region !== er || fetch_local !== el) begin
            n_fail++;
            $display("FAIL %s: got pc=%h mode=%b rgn=%b loc=%h, expected pc=%h mode=%b rgn=%b loc=%h",
                     rq, pc_value, shmem_mode, fetch_region, fetch_local, epc, em, er, el);
        end
    endtask

    task automatic drive(input logic s, input logic t, input logic r,
                         input logic [PC_W-1:0] a, input logic [OFS_W-1:0] o);
        step_en = s; br_take = t; br_rel = r; br_abs_tgt = a; br_ofs = o;
    endtask

    initial begin
        rst = 1'b1;
        drive(1'b0, 1'b0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        check("R1", 20'h0, 1'b0, 2'b00, 20'h0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].step, VEC[i].take, VEC[i].rel, VEC[i].abs_tgt, VEC[i].ofs);
            @(negedge clk);
            check(tag(int'(VEC[i].req)), VEC[i].exp_pc, VEC[i].exp_mode,
                  VEC[i].exp_rgn, VEC[i].exp_loc);
        end

        // R1: reset wins over a pending branch while in shared mode
        rst = 1'b1;
        drive(1'b1, 1'b1, 1'b0, 20'h00900, '0);
        @(negedge clk);
        check("R1", 20'h0, 1'b0, 2'b00, 20'h0);
        rst = 1'b0;

        // R4 + R6: relative sum wraps below zero into shared space
        drive(1'b1, 1'b1, 1'b1, '0, 9'h1FE);
        @(negedge clk);
        check("R4", 20'hFFFFF, 1'b1, 2'b10, 20'hFFFFF);

        // R8: absolute jump to top of register memory
        drive(1'b1, 1'b1, 1'b0, 20'h001FF, '0);
        @(negedge clk);
        check("R8", 20'h001FF, 1'b0, 2'b00, 20'h001FF);

        // R8: one step crosses into lookup memory
        drive(1'b1, 1'b0, 1'b0, '0, '0);
        @(negedge clk);
        check("R8", 20'h00200, 1'b0, 2'b01, 20'h00000);

        drive(1'b0, 1'b0, 1'b0, '0, '0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule